// File: doc/BRIEF.md
# Byte-Addressed DMA Engine Register Block

This block is the host-facing register file of a scripted DMA engine. A host reads and writes single bytes over a 7-bit address. Addresses below 0x60 are decoded and everything above is dead space. The 32-bit engine registers (script pointer, source address, scratch word) and the 24-bit transfer count are spread across consecutive byte addresses, least significant byte first. The assembled values are presented continuously to the engine's sequencer.

Some writes do more than store a byte. Completing the script pointer, by writing its top byte, releases a halted engine. Unless the manual-start mode bit is set, that same write also launches free-running execution. A write to the control byte can ask for one single step or for a free-running start. Both launch requests leave the block as one-cycle pulses.

The sequencer reports events back through set pulses that raise the interrupt-pending flag and the DMA status bits. The interrupt line stays high until the host reads the DMA status byte. That read returns the status as it stood before the read, and then clears the pending flag and the step-done bit.

Top module: `dma_regblk`

## Requirements
- R1: Addresses 0x60 to 0x7F are invalid: a write there changes no register, and a read there returns 0x00.
- R2: After reset, DMA status (0x0C) reads 0x80, and bytes 0x00=0xC0, 0x0F=0x02, 0x18=0xFF, 0x19=0xF0, 0x1A=0x01, 0x46=0x60, 0x47=0x0F, 0x4C=0x03; every other byte is 0x00 and `halted` is low.
- R3: The engine fields are little-endian by byte lane and appear on the outputs: `eng_temp` at 0x1C..0x1F, `eng_count` at 0x24..0x26, `eng_cmd` at 0x27, `eng_ptr` at 0x2C..0x2F and `eng_src` at 0x30..0x33.
- R4: A write to 0x2F clears `halted` on the next cycle. If bit 0 of the mode byte 0x38 (`manual_mode`) is 0, the write also raises `start_pulse` for exactly the following cycle; if the bit is 1, no pulse is produced. A `seq_halt` pulse sets `halted`.
- R5: A write to the control byte 0x3B with bits 4 and 2 both set raises `step_pulse` for one cycle. With bit 2 set and bit 4 clear, it raises `start_pulse` for one cycle. With bit 2 clear, neither pulse is raised. The written value can be read back.
- R6: A read of 0x0C returns the status as it stood before the read. The read then clears bit 0 of the interrupt byte 0x14 (pending) and bit 3 of 0x0C (step done).
- R7: `irq` is high while either bit 0 of 0x14 or bit 3 of 0x0C is set, and it stays high until a clearing read or a host write of 0x14 with bit 0 clear.
- R8: A `seq_set_pend` pulse, or a `seq_set_stat` bit, that arrives in the same cycle as a clearing read wins: the bit stays set afterwards.
- R9: Every valid address without special meaning is plain read/write storage. Byte 0x14 is host-writable. Byte 0x0C cannot be written by the host.
- R10: Read data appears on `rd_data`, with `rd_valid` high, in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host byte write strobe |
| rd_en | input | 1 | Host byte read strobe |
| addr | input | 7 | Byte address shared by read and write |
| wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read data |
| seq_set_pend | input | 1 | Sequencer sets the interrupt-pending bit |
| seq_set_stat | input | 8 | Sequencer sets DMA status bits (bitwise OR) |
| seq_halt | input | 1 | Sequencer reports the engine halted |
| start_pulse | output | 1 | One-cycle free-running start request |
| step_pulse | output | 1 | One-cycle single-step request |
| halted | output | 1 | Engine halt flag |
| manual_mode | output | 1 | Mode byte bit 0: pointer writes do not auto-start |
| irq | output | 1 | Interrupt request |
| eng_ptr | output | 32 | Script pointer |
| eng_src | output | 32 | Source address |
| eng_temp | output | 32 | Scratch word |
| eng_count | output | 24 | Transfer byte count |
| eng_cmd | output | 8 | Command byte |

## Verification
The bench builds the block with its default parameters: a 7-bit address and 96 decoded bytes. This leaves the 32 addresses from 0x60 to 0x7F reachable, so the dead range can be probed for both reads and writes. Directed scenarios step through pointer completion with the mode bit set and then clear, the three kinds of control-byte write, and a status read that coincides with a sequencer set pulse.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  // Byte offsets whose meaning the block decodes
  localparam int unsigned OFS_STAT = 'h0C;
  localparam int unsigned OFS_IRQ  = 'h14;
  localparam int unsigned OFS_TEMP = 'h1C;
  localparam int unsigned OFS_CNT  = 'h24;
  localparam int unsigned OFS_CMD  = 'h27;
  localparam int unsigned OFS_PTR  = 'h2C;
  localparam int unsigned OFS_SRC  = 'h30;
  localparam int unsigned OFS_MODE = 'h38;
  localparam int unsigned OFS_CTRL = 'h3B;

  // Bit positions
  localparam int unsigned CTRL_GO_BIT   = 2;
  localparam int unsigned CTRL_STEP_BIT = 4;
  localparam int unsigned MODE_MAN_BIT  = 0;
  localparam int unsigned STAT_STEP_BIT = 3;
  localparam int unsigned IRQ_PEND_BIT  = 0;

  localparam logic [7:0] STAT_RESET = 8'h80;

  // Power-up contents of the plain storage bytes
  function automatic logic [7:0] rst_byte(input int unsigned a);
    case (a)
      'h00:    return 8'hC0;
      'h0F:    return 8'h02;
      'h18:    return 8'hFF;
      'h19:    return 8'hF0;
      'h1A:    return 8'h01;
      'h46:    return 8'h60;
      'h47:    return 8'h0F;
      'h4C:    return 8'h03;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/dma_reg_store.sv
module dma_reg_store
  import dma_reg_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int REG_BYTES = 96
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [REG_BYTES*8-1:0] bytes_o
);
  for (genvar g = 0; g < REG_BYTES; g++) begin : g_byte
    localparam logic [7:0] RV = rst_byte(g);
    localparam bit HOST_WR = (g != OFS_STAT) && (g != OFS_IRQ);
    logic [7:0] q;
    if (HOST_WR) begin : g_rw
      always_ff @(posedge clk) begin
        if (!rst_n)                                  q <= RV;
        else if (wr_en && addr == ADDR_W'(g))        q <= wdata;
      end
    end else begin : g_fixed
      // owned by the status unit; slot kept constant
      assign q = RV;
    end
    assign bytes_o[g*8 +: 8] = q;
  end
endmodule

// File: rtl/dma_launch.sv
module dma_launch
  import dma_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ptr_top,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  input  logic       manual,
  input  logic       seq_halt,
  output logic       start_pulse,
  output logic       step_pulse,
  output logic       halted
);
  logic want_step, want_go;

  always_comb begin
    want_step = wr_ctrl && wdata[CTRL_GO_BIT] && wdata[CTRL_STEP_BIT];
    want_go   = (wr_ptr_top && !manual) ||
                (wr_ctrl && wdata[CTRL_GO_BIT] && !wdata[CTRL_STEP_BIT]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      step_pulse  <= 1'b0;
      halted      <= 1'b0;
    end else begin
      start_pulse <= want_go;
      step_pulse  <= want_step;
      if (seq_halt)        halted <= 1'b1;
      else if (wr_ptr_top) halted <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_status.sv
module dma_status
  import dma_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_irq_byte,
  input  logic [7:0] wdata,
  input  logic       rd_stat,
  input  logic       set_pend,
  input  logic [7:0] set_stat,
  output logic [7:0] stat_q,
  output logic [7:0] irqb_q,
  output logic       irq
);
  logic [7:0] stat_d, irqb_d;

  // order: host write, clearing read, then sequencer sets (sets win)
  always_comb begin
    irqb_d = wr_irq_byte ? wdata : irqb_q;
    stat_d = stat_q;
    if (rd_stat) begin
      irqb_d[IRQ_PEND_BIT]  = 1'b0;
      stat_d[STAT_STEP_BIT] = 1'b0;
    end
    if (set_pend) irqb_d[IRQ_PEND_BIT] = 1'b1;
    stat_d = stat_d | set_stat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= STAT_RESET;
      irqb_q <= 8'h00;
    end else begin
      stat_q <= stat_d;
      irqb_q <= irqb_d;
    end
  end

  assign irq = irqb_q[IRQ_PEND_BIT] | stat_q[STAT_STEP_BIT];
endmodule

// File: rtl/dma_regblk.sv
module dma_regblk
  import dma_reg_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int REG_BYTES = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              seq_set_pend,
  input  logic [7:0]        seq_set_stat,
  input  logic              seq_halt,
  output logic              start_pulse,
  output logic              step_pulse,
  output logic              halted,
  output logic              manual_mode,
  output logic              irq,
  output logic [31:0]       eng_ptr,
  output logic [31:0]       eng_src,
  output logic [31:0]       eng_temp,
  output logic [23:0]       eng_count,
  output logic [7:0]        eng_cmd
);
  localparam int FLAT_W = REG_BYTES * 8;

  logic             in_range;
  logic             wr_ok;
  logic [FLAT_W-1:0] flat;
  logic [7:0]       stat_q, irqb_q, rd_mux;

  assign in_range = int'(addr) < REG_BYTES;
  assign wr_ok    = wr_en && in_range;

  dma_reg_store #(.ADDR_W(ADDR_W), .REG_BYTES(REG_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .addr(addr),
    .wdata(wdata), .bytes_o(flat)
  );

  dma_launch u_launch (
    .clk(clk), .rst_n(rst_n),
    .wr_ptr_top(wr_ok && addr == ADDR_W'(OFS_PTR + 3)),
    .wr_ctrl(wr_ok && addr == ADDR_W'(OFS_CTRL)),
    .wdata(wdata), .manual(manual_mode), .seq_halt(seq_halt),
    .start_pulse(start_pulse), .step_pulse(step_pulse), .halted(halted)
  );

  dma_status u_status (
    .clk(clk), .rst_n(rst_n),
    .wr_irq_byte(wr_ok && addr == ADDR_W'(OFS_IRQ)),
    .wdata(wdata),
    .rd_stat(rd_en && addr == ADDR_W'(OFS_STAT)),
    .set_pend(seq_set_pend), .set_stat(seq_set_stat),
    .stat_q(stat_q), .irqb_q(irqb_q), .irq(irq)
  );

  assign manual_mode = flat[OFS_MODE*8 + MODE_MAN_BIT];
  assign eng_temp    = flat[OFS_TEMP*8 +: 32];
  assign eng_count   = flat[OFS_CNT*8  +: 24];
  assign eng_cmd     = flat[OFS_CMD*8  +: 8];
  assign eng_ptr     = flat[OFS_PTR*8  +: 32];
  assign eng_src     = flat[OFS_SRC*8  +: 32];

  always_comb begin
    rd_mux = 8'h00;
    if (addr == ADDR_W'(OFS_STAT))     rd_mux = stat_q;
    else if (addr == ADDR_W'(OFS_IRQ)) rd_mux = irqb_q;
    else begin
      for (int i = 0; i < REG_BYTES; i++)
        if (addr == ADDR_W'(i)) rd_mux = flat[i*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_regblk_chk.sv
module dma_regblk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [6:0]  addr,
  input logic [7:0]  wdata,
  input logic        rd_valid,
  input logic [7:0]  rd_data,
  input logic        seq_set_pend,
  input logic [7:0]  seq_set_stat,
  input logic        seq_halt,
  input logic        start_pulse,
  input logic        step_pulse,
  input logic        halted,
  input logic        manual_mode,
  input logic        irq,
  input logic [31:0] eng_ptr,
  input logic [31:0] eng_src,
  input logic [31:0] eng_temp,
  input logic [23:0] eng_count,
  input logic [7:0]  eng_cmd
);
  // R1
  p_dead_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr >= 7'h60 |=> rd_data == 8'h00);
  p_dead_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr >= 7'h60 |=> $stable(eng_ptr) && $stable(eng_src) && $stable(eng_temp));
  // R4
  p_ptr_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 7'h2F && !manual_mode |=> start_pulse);
  p_ptr_unhalt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 7'h2F && !seq_halt |=> !halted);
  // R5
  p_step_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 7'h3B && wdata[4] && wdata[2] |=> step_pulse && !start_pulse);
  p_ctrl_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 7'h3B && !wdata[2] |=> !step_pulse && !start_pulse);
  // R6
  p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == 7'h0C && !seq_set_pend && !seq_set_stat[3] |=> !irq);
  // R7
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !(rd_en && addr == 7'h0C) && !(wr_en && addr == 7'h14) |=> irq);
  // R8
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_set_pend |=> irq);
  // R10
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
endmodule

bind dma_regblk dma_regblk_chk u_chk (.*);

// File: tb/dma_regblk_bench.sv
`timescale 1ns/1ps
module dma_regblk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        seq_set_pend = 1'b0;
  logic [7:0]  seq_set_stat = '0;
  logic        seq_halt = 1'b0;
  logic        start_pulse, step_pulse, halted, manual_mode, irq;
  logic [31:0] eng_ptr, eng_src, eng_temp;
  logic [23:0] eng_count;
  logic [7:0]  eng_cmd;

  int n_chk = 0, n_err = 0;
  logic got_start, got_step;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  dma_regblk u_dma_regblk (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    got_start = start_pulse;
    got_step  = step_pulse;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    chk("R10 rd_valid", rd_valid, 1'b1);
    @(negedge clk);
    chk("R10 rd_valid drop", rd_valid, 1'b0);
  endtask

  function automatic logic [7:0] exp_rst(input int a);
    case (a)
      'h00: return 8'hC0; 'h0C: return 8'h80; 'h0F: return 8'h02;
      'h18: return 8'hFF; 'h19: return 8'hF0; 'h1A: return 8'h01;
      'h46: return 8'h60; 'h47: return 8'h0F; 'h4C: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  task automatic t_reset();
    int list[12] = '{'h00, 'h0C, 'h0F, 'h18, 'h19, 'h1A, 'h46, 'h47, 'h4C, 'h14, 'h2C, 'h5F};
    foreach (list[k]) begin
      rd(7'(list[k]), got);
      chk($sformatf("R2 reset byte %0h", list[k]), got, exp_rst(list[k]));
    end
    chk("R2 halted reset", halted, 1'b0);
    chk("R2 irq reset", irq, 1'b0);
  endtask

  task automatic t_storage();
    wr(7'h40, 8'h5A); rd(7'h40, got); chk("R9 plain byte", got, 8'h5A);
    wr(7'h0C, 8'h55); rd(7'h0C, got); chk("R9 status not writable", got, 8'h80);
    wr(7'h14, 8'hA4); rd(7'h14, got); chk("R9 irq byte writable", got, 8'hA4);
    wr(7'h14, 8'h00);
  endtask

  task automatic t_invalid();
    logic [31:0] p0;
    p0 = eng_ptr;
    wr(7'h60, 8'hAB); wr(7'h7F, 8'hCD);
    rd(7'h60, got); chk("R1 dead read 60", got, 8'h00);
    rd(7'h7F, got); chk("R1 dead read 7F", got, 8'h00);
    rd(7'h20, got); chk("R1 no alias", got, 8'h00);
    chk("R1 ptr unchanged", eng_ptr, p0);
    chk("R1 no launch", got_start, 1'b0);
  endtask

  task automatic t_fields();
    wr(7'h38, 8'h01);
    chk("R4 manual_mode", manual_mode, 1'b1);
    wr(7'h2C, 8'h11); wr(7'h2D, 8'h22); wr(7'h2E, 8'h33); wr(7'h2F, 8'h44);
    chk("R4 no start when manual", got_start, 1'b0);
    chk("R3 ptr", eng_ptr, 32'h44332211);
    wr(7'h30, 8'hEF); wr(7'h31, 8'hBE); wr(7'h32, 8'hAD); wr(7'h33, 8'hDE);
    chk("R3 src", eng_src, 32'hDEADBEEF);
    wr(7'h1C, 8'h01); wr(7'h1D, 8'h02); wr(7'h1E, 8'h03); wr(7'h1F, 8'h04);
    chk("R3 temp", eng_temp, 32'h04030201);
    wr(7'h24, 8'h78); wr(7'h25, 8'h56); wr(7'h26, 8'h34); wr(7'h27, 8'hC0);
    chk("R3 count", eng_count, 24'h345678);
    chk("R3 cmd", eng_cmd, 8'hC0);
    rd(7'h2E, got); chk("R3 ptr byte readback", got, 8'h33);
  endtask

  task automatic t_ptr_launch();
    @(negedge clk); seq_halt = 1'b1; @(negedge clk); seq_halt = 1'b0;
    chk("R4 seq_halt sets", halted, 1'b1);
    wr(7'h2F, 8'h55);
    chk("R4 unhalt manual", halted, 1'b0);
    chk("R4 manual no start", got_start, 1'b0);
    wr(7'h38, 8'h00);
    @(negedge clk); seq_halt = 1'b1; @(negedge clk); seq_halt = 1'b0;
    wr(7'h2F, 8'h66);
    chk("R4 auto start", got_start, 1'b1);
    chk("R4 unhalt auto", halted, 1'b0);
    @(negedge clk);
    chk("R4 start one cycle", start_pulse, 1'b0);
  endtask

  task automatic t_ctrl();
    wr(7'h3B, 8'h14);
    chk("R5 step", got_step, 1'b1); chk("R5 step no start", got_start, 1'b0);
    wr(7'h3B, 8'h04);
    chk("R5 go", got_start, 1'b1); chk("R5 go no step", got_step, 1'b0);
    wr(7'h3B, 8'h10);
    chk("R5 idle start", got_start, 1'b0); chk("R5 idle step", got_step, 1'b0);
    rd(7'h3B, got); chk("R5 ctrl readback", got, 8'h10);
  endtask

  task automatic t_status();
    @(negedge clk); seq_set_pend = 1'b1; seq_set_stat = 8'h08;
    @(negedge clk); seq_set_pend = 1'b0; seq_set_stat = 8'h00;
    chk("R7 irq raised", irq, 1'b1);
    rd(7'h14, got); chk("R7 pend visible", got, 8'h01);
    chk("R7 irq holds over other read", irq, 1'b1);
    rd(7'h0C, got); chk("R6 read returns old", got, 8'h88);
    chk("R6 irq dropped", irq, 1'b0);
    rd(7'h0C, got); chk("R6 step bit cleared", got, 8'h80);
    rd(7'h14, got); chk("R6 pend cleared", got, 8'h00);
    // only status bit 3, no pend
    @(negedge clk); seq_set_stat = 8'h08; @(negedge clk); seq_set_stat = 8'h00;
    chk("R7 irq from step bit", irq, 1'b1);
    rd(7'h0C, got); chk("R7 cleared by read", irq, 1'b0);
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    rd_en = 1'b1; addr = 7'h0C; seq_set_pend = 1'b1; seq_set_stat = 8'h08;
    @(negedge clk);
    rd_en = 1'b0; seq_set_pend = 1'b0; seq_set_stat = 8'h00;
    chk("R8 irq survives clear", irq, 1'b1);
    rd(7'h14, got); chk("R8 pend kept", got, 8'h01);
    rd(7'h0C, got); chk("R8 step kept", got, 8'h88);
    chk("R8 later read clears", irq, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_storage();
    t_invalid();
    t_fields();
    t_ptr_launch();
    t_ctrl();
    t_status();
    t_set_wins();
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule